// File: doc/BRIEF.md
# Vector NaN Presence Scanner

The scanner watches a stream of double-precision floating-point data and reports whether any value in it is a NaN. Each accepted beat carries several vectors of four 64-bit lanes. The vectors are taken in pairs, and each pair goes through a lane-wise unordered compare, so a single compare covers eight values. The lane masks from all pairs are ORed together and then collapsed into one hit bit for the beat. That bit sets a sticky flag, which stays high until a clear pulse.

A locate stage can be built in. It tests every vector against itself and records the lowest element index of the first beat since the last clear that held a NaN. The producer may present the same element more than once. A final partial block can therefore overlap elements that were already scanned, with no masking. The beat that ends a scan is flagged as last, and the block answers with a one-cycle done pulse. On that same cycle the flag already covers the whole scan.

Top module: `nanscan_top`

## Requirements
- R1: A 64-bit value counts as NaN when its bits [62:52] are all ones and its bits [51:0] are not all zero. The sign bit does not matter. Infinities (bits [51:0] zero) and ordinary numbers never count.
- R2: With the default parameters, a beat holds 16 elements. Element e occupies `in_data[e*64 +: 64]`, where e = vector*4 + lane. A NaN in any of the 16 positions is detected.
- R3: When an accepted beat holds at least one NaN, `nan_seen` is high from the cycle after that beat's acceptance edge onward.
- R4: `nan_seen` stays high through any later beats until `clr` is sampled high. After that edge, `nan_seen` and `loc_valid` are both low. After reset, `nan_seen`, `done` and `loc_valid` are low.
- R5: `in_ready` is low in any cycle where `clr` is high. A beat presented in that cycle is not accepted and cannot set the flag.
- R6: A beat with `in_valid` low has no effect on `nan_seen` or the locate outputs, whatever its data holds.
- R7: `done` is high for exactly the one cycle after an accepted beat with `in_last` high, and low otherwise.
- R8: On the first NaN beat after reset or clear, `loc_valid` rises together with `nan_seen`, and `loc_index` gives the lowest NaN element index in that beat. Later NaN beats do not change `loc_index` until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be taken (low during clear) |
| in_data | input | 1024 | 16 doubles, element e at bits [e*64 +: 64] |
| in_last | input | 1 | Beat ends the scan |
| clr | input | 1 | Clear the sticky flag and locate result |
| nan_seen | output | 1 | Sticky NaN flag |
| done | output | 1 | One-cycle pulse after the last beat |
| loc_valid | output | 1 | Locate result held |
| loc_index | output | 4 | Lowest NaN element index in the first NaN beat |

## Verification
Three kinds of beat are driven to separate NaN from look-alike encodings:
- Beats full of normal numbers, positive and negative infinities, and zeros must leave the flag low. This separates an exponent-only test from the real NaN test.
- Quiet, signalling and negative NaNs placed at each of the 16 element positions in turn must set the flag and report that exact index. This exposes a wrong pairing, a dropped lane, or a wrong priority order.
- Beats holding several NaNs, followed by later NaN beats, show that the lowest index wins and that the first result is held.

NaN beats are also presented with `in_valid` low or together with `clr`. These confirm that unaccepted beats leave no trace on the flag or the locate outputs.

// File: rtl/nanscan_pkg.sv
package nanscan_pkg;

    localparam int unsigned ELEM_W = 64;

    // Unordered test on one operand: all-ones exponent, nonzero fraction.
    function automatic logic is_nan(input logic [ELEM_W-1:0] x);
        return (&x[62:52]) && (|x[51:0]);
    endfunction

endpackage

// File: rtl/nanscan_pair_cmp.sv
module nanscan_pair_cmp
    import nanscan_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES*ELEM_W-1:0] vec_a,
    input  logic [LANES*ELEM_W-1:0] vec_b,
    output logic [LANES-1:0]        unord
);

    // Lane i of vec_a is checked against lane i of vec_b: true if either is NaN.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign unord[l] = is_nan(vec_a[l*ELEM_W +: ELEM_W])
                        | is_nan(vec_b[l*ELEM_W +: ELEM_W]);
    end

endmodule

// File: rtl/nanscan_locate.sv
module nanscan_locate
    import nanscan_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned VECS  = 4,
    localparam int unsigned EW    = LANES * VECS,
    localparam int unsigned IDX_W = $clog2(EW)
) (
    input  logic [EW*ELEM_W-1:0] data,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);

    // Each vector is tested against itself. The scan runs downward,
    // so the lowest NaN element index is the one left in idx.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int e = EW - 1; e >= 0; e--) begin
            if (is_nan(data[e*ELEM_W +: ELEM_W])) begin
                hit = 1'b1;
                idx = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/nanscan_top.sv
module nanscan_top
    import nanscan_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned VECS   = 4,
    parameter bit          LOCATE = 1'b1,
    localparam int unsigned EW     = LANES * VECS,
    localparam int unsigned IDX_W  = $clog2(EW),
    localparam int unsigned DATA_W = EW * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              clr,
    output logic              nan_seen,
    output logic              done,
    output logic              loc_valid,
    output logic [IDX_W-1:0]  loc_index
);

    localparam int unsigned PAIRS = VECS / 2;
    localparam int unsigned VEC_W = LANES * ELEM_W;

    typedef struct packed {
        logic             nan_seen;
        logic             done;
        logic             loc_valid;
        logic [IDX_W-1:0] loc_idx;
    } state_t;

    state_t st_d, st_q;

    logic [PAIRS-1:0][LANES-1:0] pair_mask;
    logic [LANES-1:0]            fold_mask;
    logic                        beat_hit;
    logic                        accept;
    logic                        loc_hit;
    logic [IDX_W-1:0]            loc_idx_now;

    // Vectors 2p and 2p+1 share one unordered compare.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        nanscan_pair_cmp #(.LANES(LANES)) u_cmp (
            .vec_a (in_data[(2*p)*VEC_W   +: VEC_W]),
            .vec_b (in_data[(2*p+1)*VEC_W +: VEC_W]),
            .unord (pair_mask[p])
        );
    end

    // The pair masks are ORed lane by lane, then the result is reduced to one bit.
    always_comb begin
        fold_mask = '0;
        for (int p = 0; p < int'(PAIRS); p++) begin
            fold_mask = fold_mask | pair_mask[p];
        end
        beat_hit = |fold_mask;
    end

    if (LOCATE) begin : g_loc
        nanscan_locate #(.LANES(LANES), .VECS(VECS)) u_loc (
            .data (in_data),
            .hit  (loc_hit),
            .idx  (loc_idx_now)
        );
    end else begin : g_noloc
        assign loc_hit     = 1'b0;
        assign loc_idx_now = '0;
    end

    assign in_ready = !clr;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d      = st_q;
        st_d.done = accept && in_last;
        if (clr) begin
            st_d.nan_seen  = 1'b0;
            st_d.loc_valid = 1'b0;
            st_d.loc_idx   = '0;
        end else if (accept && beat_hit) begin
            st_d.nan_seen = 1'b1;
            if (!st_q.loc_valid && loc_hit) begin
                st_d.loc_valid = 1'b1;
                st_d.loc_idx   = loc_idx_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nan_seen  = st_q.nan_seen;
    assign done      = st_q.done;
    assign loc_valid = st_q.loc_valid;
    assign loc_index = st_q.loc_idx;

    // ---------------- assertions ----------------
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nan_seen && !clr |=> nan_seen);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !nan_seen && !loc_valid);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && !clr && in_last));

    p_loc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && !clr |=> loc_valid && $stable(loc_index));

    p_loc_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |-> nan_seen);

    // The pairwise fold and the self-compare locate path are separate logic
    // and must agree on whether the beat holds a NaN.
    p_paths_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (!LOCATE || (loc_hit == beat_hit)));

endmodule

// File: tb/nanscan_top_bench.sv
module nanscan_top_bench;

    localparam int DW = 1024;
    localparam logic [63:0] F_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] F_NEG  = 64'hC00A_0000_0000_0000;
    localparam logic [63:0] F_PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] F_NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] F_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] F_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] F_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] F_NNAN = 64'hFFF8_0000_0000_0123;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          in_last;
    logic          clr;
    logic          nan_seen;
    logic          done;
    logic          loc_valid;
    logic [3:0]    loc_index;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    nanscan_top u_nanscan_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .clr       (clr),
        .nan_seen  (nan_seen),
        .done      (done),
        .loc_valid (loc_valid),
        .loc_index (loc_index)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] clean_beat();
        logic [DW-1:0] b;
        for (int e = 0; e < 16; e++) begin
            case (e % 5)
                0: b[e*64 +: 64] = F_ONE;
                1: b[e*64 +: 64] = F_PINF;
                2: b[e*64 +: 64] = F_NINF;
                3: b[e*64 +: 64] = F_ZERO;
                default: b[e*64 +: 64] = F_NEG;
            endcase
        end
        return b;
    endfunction

    function automatic logic [DW-1:0] put(input logic [DW-1:0] b, input int e, input logic [63:0] v);
        logic [DW-1:0] r = b;
        r[e*64 +: 64] = v;
        return r;
    endfunction

    // Drives for one cycle; on return the outputs show that edge's result.
    task automatic drive(input logic [DW-1:0] d, input logic v, input logic l, input logic c);
        @(negedge clk);
        in_data = d; in_valid = v; in_last = l; clr = c;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R4 reset nan_seen", int'(nan_seen), 0);
        check("R4 reset done", int'(done), 0);
        check("R4 reset loc_valid", int'(loc_valid), 0);
        check("R5 ready idle", int'(in_ready), 1);
    endtask

    task automatic t_clean();
        drive(clean_beat(), 1, 0, 0);
        check("R1 infinities/normals not NaN", int'(nan_seen), 0);
        check("R7 no done without last", int'(done), 0);
    endtask

    task automatic t_first_hit();
        drive(put(clean_beat(), 9, F_SNAN), 1, 0, 0);
        check("R3 flag after snan beat", int'(nan_seen), 1);
        check("R8 loc_valid", int'(loc_valid), 1);
        check("R8 loc_index", int'(loc_index), 9);
        drive(put(clean_beat(), 2, F_QNAN), 1, 0, 0);
        check("R8 index held", int'(loc_index), 9);
        drive(clean_beat(), 1, 0, 0);
        check("R4 sticky over clean beat", int'(nan_seen), 1);
    endtask

    task automatic t_clear_blocks();
        @(negedge clk);
        clr = 1'b1;
        #0.5;
        check("R5 ready low during clr", int'(in_ready), 0);
        clr = 1'b0;
        drive(put(clean_beat(), 0, F_QNAN), 1, 0, 1);
        check("R4 cleared flag", int'(nan_seen), 0);
        check("R5 beat with clr ignored loc", int'(loc_valid), 0);
    endtask

    task automatic t_invalid();
        drive(put(clean_beat(), 3, F_NNAN), 0, 1, 0);
        check("R6 invalid beat ignored", int'(nan_seen), 0);
        check("R6 invalid no loc", int'(loc_valid), 0);
        check("R7 invalid last no done", int'(done), 0);
    endtask

    task automatic t_last();
        drive(clean_beat(), 1, 1, 0);
        check("R7 done after last", int'(done), 1);
        check("R7 clean scan flag low", int'(nan_seen), 0);
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_multi();
        logic [DW-1:0] b = clean_beat();
        drive(b, 0, 0, 1);
        b = put(b, 14, F_QNAN);
        b = put(b, 5, F_NNAN);
        b = put(b, 15, F_SNAN);
        drive(b, 1, 1, 0);
        check("R8 lowest of several", int'(loc_index), 5);
        check("R7 done with nan", int'(done), 1);
        check("R3 flag with done", int'(nan_seen), 1);
    endtask

    task automatic t_positions();
        for (int e = 0; e < 16; e++) begin
            drive(clean_beat(), 0, 0, 1);
            drive(put(clean_beat(), e, (e % 2) ? F_SNAN : F_NNAN), 1, 0, 0);
            check("R2 detect at position", int'(nan_seen), 1);
            check("R2 index of position", int'(loc_index), e);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; clr = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_first_hit();
        t_clear_blocks();
        t_invalid();
        t_last();
        t_multi();
        t_positions();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule